// File: doc/BRIEF.md
# Flash Line Prefetch Accelerator

This block sits between a requester that reads 32-bit words and a slow flash array that returns 128-bit lines. It holds a few recently read or predicted lines in tagged line buffers, so most word reads complete without waiting for the flash. A configuration register sets the access mode and the flash latency, which is the number of clocks one line read takes. Off mode forwards every access straight to the flash. Partial mode keeps the line currently being executed and reads the next sequential line ahead of time. Full mode adds two more buffers. One keeps the target line of a backward jump, so a loop can start again without a flash wait. The other keeps the last line read for data, apart from the instruction stream.

The requester port uses valid/ready. The requester raises `req_valid` with a word-aligned address and a data/instruction flag. It must hold all three unchanged until the cycle in which `req_ready` is high; `req_rdata` is valid in that cycle only. A hit completes in the same cycle the request is presented. A miss stalls the requester until the line arrives. The flash side has no handshake. The accelerator keeps `fl_rd` high and `fl_addr` steady for the whole programmed latency, and it takes `fl_line` in the last clock of that window.

Top module: `flash_prefetch_accel`

## Requirements
- R1: Addresses are byte addresses with bits 1:0 zero. The line tag is address bits AW-1:4, and bits 3:2 select word k of the line, which is `fl_line[32k+31:32k]`.
- R2: After reset the mode is off and the latency is 7 clocks. A configuration write of latency 0 is stored as 1. Mode code 0 is off, 1 is partial, and 2 or 3 is full.
- R3: A line read keeps `fl_rd` high with a constant `fl_addr` for exactly the programmed number of clocks. The line is taken in the last of those clocks. `fl_rd` is low when no read is in progress.
- R4: In off mode every access, including a repeat of the same address, gets `req_ready` in exactly the latency-th cycle of the request. Nothing is buffered and nothing is prefetched.
- R5: In partial or full mode, once an instruction line has arrived, the read of the next sequential line starts in the following cycle.
- R6: In partial mode, with a latency of 4 or less, a sequential instruction stream completes one word per cycle once its first line has arrived.
- R7: An access that hits a valid buffer gets `req_ready` in the cycle it is first presented.
- R8: An access that misses every buffer cancels any read in progress for another line and starts its own line in the same cycle, so it completes in exactly the latency.
- R9: In full mode, the line reached by a backward jump (a target line below the current instruction line) is kept. The next jump back to that line hits with no wait.
- R10: In full mode, data reads fill a data buffer that later data reads to the same line hit, and the instruction buffers are left as they were. In partial mode, data reads are not retained.
- R11: A configuration write empties every buffer and cancels any read in progress.
- R12: `req_ready` is never high while `req_valid` is low. A stalled request keeps its address and flag until it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the mode and latency register |
| cfg_mode | input | 2 | Mode code to write (0 off, 1 partial, 2/3 full) |
| cfg_wait | input | 3 | Clocks per flash line read (0 is stored as 1) |
| req_valid | input | 1 | Requester has a word access pending |
| req_addr | input | AW | Byte address of the word |
| req_is_data | input | 1 | 1 for a data read, 0 for an instruction fetch |
| req_ready | output | 1 | Access completes this cycle |
| req_rdata | output | 32 | Word returned, valid with req_ready |
| fl_rd | output | 1 | Flash line read in progress |
| fl_addr | output | AW-4 | Line tag being read |
| fl_line | input | 128 | Line returned by the flash |

## Verification
The bench aims at the exact cycle counts that show whether the right line was fetched at the right time. It streams sequential code at latencies 4 and 2. A prefetch that starts a cycle late, or a line that is not forwarded in its last read cycle, shows up as a stalled word. It sends a miss while a prefetch is in flight. A design that lets the prefetch finish first would take longer than the latency. It runs a three-line loop in full mode, where a lost branch target would make the third pass wait. It also interleaves data and instruction reads, where a data fill that overwrites the instruction buffer would turn a one-cycle hit into a flash wait.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PART = 2'd1,
    MODE_FULL = 2'd2
  } fpa_mode_e;

  localparam int NBUF   = 4;
  localparam int BUF_IB = 0;  // line being executed
  localparam int BUF_PB = 1;  // next sequential line
  localparam int BUF_BT = 2;  // backward jump target
  localparam int BUF_DB = 3;  // data line

  localparam int WORD_W  = 32;
  localparam int LINE_W  = 128;
  localparam int WSEL_W  = 2;
  localparam int LAT_W   = 3;

endpackage

// File: rtl/fpa_line_buf.sv
module fpa_line_buf
  import fpa_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld,
  input  logic [TW-1:0]     ld_tag,
  input  logic [LINE_W-1:0] ld_line,
  input  logic [TW-1:0]     lk_tag,
  input  logic [WSEL_W-1:0] lk_sel,
  output logic              vld,
  output logic [TW-1:0]     tag,
  output logic [LINE_W-1:0] line,
  output logic              hit,
  output logic [WORD_W-1:0] word
);

  // Valid bit: a load wins over a clear, so the caller gates loads with
  // the configuration write when that must win.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= 1'b0;
    else if (ld)  vld <= 1'b1;
    else if (clr) vld <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag  <= '0;
      line <= '0;
    end else if (ld) begin
      tag  <= ld_tag;
      line <= ld_line;
    end
  end

  assign hit  = vld && (tag == lk_tag);
  assign word = line[{lk_sel, 5'b0} +: WORD_W];

endmodule

// File: rtl/fpa_read_seq.sv
module fpa_read_seq
  import fpa_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] lat,
  input  logic             cancel,
  input  logic             start,
  input  logic [TW-1:0]    start_tag,
  output logic             busy,
  output logic [TW-1:0]    rd_tag,
  output logic             fl_rd,
  output logic [TW-1:0]    fl_tag,
  output logic             done
);

  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] cur_cnt;

  // A start restarts the window at count zero, on a new or the same tag.
  assign cur_cnt = start ? '0 : cnt;
  assign fl_rd   = busy || start;
  assign fl_tag  = start ? start_tag : rd_tag;
  assign done    = fl_rd && (cur_cnt == LAT_W'(lat - LAT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      rd_tag <= '0;
    end else if (cancel) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (fl_rd && !done) begin
      busy   <= 1'b1;
      cnt    <= cur_cnt + LAT_W'(1);
      rd_tag <= fl_tag;
    end else begin
      busy <= 1'b0;
      cnt  <= '0;
    end
  end

  // R3: the read window never runs past the programmed latency
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < lat));

endmodule

// File: rtl/flash_prefetch_accel.sv
module flash_prefetch_accel
  import fpa_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [2:0]        cfg_wait,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_is_data,
  output logic              req_ready,
  output logic [31:0]       req_rdata,
  output logic              fl_rd,
  output logic [AW-5:0]     fl_addr,
  input  logic [127:0]      fl_line
);

  localparam int TW = AW - 4;

  // ---------------- configuration register ----------------
  fpa_mode_e        mode_q;
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      lat_q  <= LAT_W'(7);
    end else if (cfg_we) begin
      mode_q <= (cfg_mode[1]) ? MODE_FULL : fpa_mode_e'(cfg_mode);
      lat_q  <= (cfg_wait == '0) ? LAT_W'(1) : cfg_wait;
    end
  end

  logic use_bufs, full;
  assign use_bufs = (mode_q != MODE_OFF);
  assign full     = (mode_q == MODE_FULL);

  // ---------------- request decode ----------------
  logic [TW-1:0]     req_tag;
  logic [WSEL_W-1:0] req_sel;
  logic              instr;
  assign req_tag = req_addr[AW-1:4];
  assign req_sel = req_addr[3:2];
  assign instr   = !req_is_data;

  // ---------------- line buffers ----------------
  logic [NBUF-1:0]   b_vld, b_hit, b_ld, b_clr;
  logic [TW-1:0]     b_tag     [NBUF];
  logic [LINE_W-1:0] b_line    [NBUF];
  logic [WORD_W-1:0] b_word    [NBUF];
  logic [TW-1:0]     b_ld_tag  [NBUF];
  logic [LINE_W-1:0] b_ld_line [NBUF];

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
    fpa_line_buf #(.TW(TW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (b_clr[gi]),
      .ld      (b_ld[gi]),
      .ld_tag  (b_ld_tag[gi]),
      .ld_line (b_ld_line[gi]),
      .lk_tag  (req_tag),
      .lk_sel  (req_sel),
      .vld     (b_vld[gi]),
      .tag     (b_tag[gi]),
      .line    (b_line[gi]),
      .hit     (b_hit[gi]),
      .word    (b_word[gi])
    );
  end

  logic              hit_any;
  logic [WORD_W-1:0] hit_word;
  assign hit_any = req_valid && (|b_hit);

  always_comb begin
    hit_word = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (b_hit[i]) hit_word = b_word[i];
    end
  end

  // ---------------- flash read sequencer ----------------
  logic          seq_busy, seq_start, seq_done;
  logic [TW-1:0] seq_rd_tag, seq_start_tag, pf_tag;
  logic          demand_miss, pf_go;

  assign pf_tag      = b_tag[BUF_IB] + TW'(1);
  assign demand_miss = req_valid && !hit_any &&
                       !(seq_busy && (seq_rd_tag == req_tag));
  assign pf_go       = use_bufs && !seq_busy && !demand_miss && !cfg_we &&
                       b_vld[BUF_IB] &&
                       !(b_vld[BUF_PB] && (b_tag[BUF_PB] == pf_tag));
  assign seq_start     = demand_miss || pf_go;
  assign seq_start_tag = demand_miss ? req_tag : pf_tag;

  fpa_read_seq #(.TW(TW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat       (lat_q),
    .cancel    (cfg_we),
    .start     (seq_start),
    .start_tag (seq_start_tag),
    .busy      (seq_busy),
    .rd_tag    (seq_rd_tag),
    .fl_rd     (fl_rd),
    .fl_tag    (fl_addr),
    .done      (seq_done)
  );

  // The line completing this cycle serves the pending request directly.
  logic done_dem;
  assign done_dem = seq_done && req_valid && !hit_any && (fl_addr == req_tag);

  assign req_ready = req_valid && (hit_any || done_dem);
  assign req_rdata = hit_any ? hit_word : fl_line[{req_sel, 5'b0} +: WORD_W];

  // ---------------- buffer fill and promotion ----------------
  logic backward;
  assign backward = b_vld[BUF_IB] && (req_tag < b_tag[BUF_IB]);

  always_comb begin
    b_ld  = '0;
    b_clr = {NBUF{cfg_we}};
    for (int i = 0; i < NBUF; i++) begin
      b_ld_tag[i]  = fl_addr;
      b_ld_line[i] = fl_line;
    end
    if (!cfg_we && use_bufs) begin
      if (done_dem && instr) begin
        b_ld[BUF_IB] = 1'b1;
        if (full && backward) b_ld[BUF_BT] = 1'b1;
      end else if (req_valid && instr && !b_hit[BUF_IB] && b_hit[BUF_PB]) begin
        b_ld[BUF_IB]      = 1'b1;
        b_ld_tag[BUF_IB]  = b_tag[BUF_PB];
        b_ld_line[BUF_IB] = b_line[BUF_PB];
        b_clr[BUF_PB]     = 1'b1;
      end else if (req_valid && instr && !b_hit[BUF_IB] && b_hit[BUF_BT]) begin
        b_ld[BUF_IB]      = 1'b1;
        b_ld_tag[BUF_IB]  = b_tag[BUF_BT];
        b_ld_line[BUF_IB] = b_line[BUF_BT];
      end
      if (done_dem && req_is_data && full) b_ld[BUF_DB] = 1'b1;
      if (seq_done && !done_dem)           b_ld[BUF_PB] = 1'b1;
    end
  end

  // ---------------- assertions ----------------
  // R1: only word-aligned addresses are presented
  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00));

  // R2: the latency register never holds zero
  p_lat_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q != '0);

  // R4: off mode never holds a valid line
  p_off_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |-> (b_vld == '0));

  // R8: a miss drives its own line to the flash in the same cycle
  p_miss_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    demand_miss |-> (fl_rd && (fl_addr == req_tag)));

  // R11: a configuration write leaves every buffer empty
  p_cfg_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (b_vld == '0));

  // R12: a stalled request is held unchanged
  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_is_data)));

endmodule

// File: tb/tb_flash_prefetch_accel.sv
`timescale 1ns/1ps
module tb_flash_prefetch_accel;

  localparam int AW = 20;
  localparam int TW = AW - 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [2:0]    cfg_wait = 3'd7;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_is_data = 1'b0;
  logic          req_ready;
  logic [31:0]   req_rdata;
  logic          fl_rd;
  logic [TW-1:0] fl_addr;
  logic [127:0]  fl_line;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // Flash model: word k of line t is {C3A, t, k, 00}
  always_comb begin
    for (int k = 0; k < 4; k++)
      fl_line[32*k +: 32] = {12'hC3A, fl_addr, 2'(k), 2'b00};
  end

  flash_prefetch_accel #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_addr(req_addr), .req_is_data(req_is_data),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_line(fl_line)
  );

  function automatic logic [31:0] ew(input logic [AW-1:0] a);
    return {12'hC3A, a[AW-1:2], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [2:0] w);
    cfg_we = 1'b1; cfg_mode = m; cfg_wait = w;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // One access; called at a negedge, returns at the negedge after ready.
  task automatic access(input logic [AW-1:0] a, input bit d, output int lat,
                        output logic [31:0] data, output logic [TW-1:0] fl0,
                        output bit fl0_rd);
    req_addr = a; req_is_data = d; req_valid = 1'b1;
    lat = 0; data = '0; fl0 = '0; fl0_rd = 1'b0;
    forever begin
      #1;
      lat++;
      if (lat == 1) begin fl0 = fl_addr; fl0_rd = fl_rd; end
      if (req_ready) begin data = req_rdata; break; end
      if (lat > 40) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic acc_chk(input logic [AW-1:0] a, input bit d, input int elat,
                         input string rq);
    int lat; logic [31:0] dat; logic [TW-1:0] f0; bit fr;
    access(a, d, lat, dat, f0, fr);
    chk(dat == ew(a), "R1 data", dat, ew(a));
    if (elat > 0) chk(lat == elat, rq, 32'(lat), 32'(elat));
  endtask

  task automatic t_reset();
    #1;
    chk(req_ready == 1'b0, "R12 ready idle", 32'(req_ready), 0);
    chk(fl_rd == 1'b0, "R3 no read idle", 32'(fl_rd), 0);
    acc_chk(20'h00010, 0, 7, "R2 reset latency 7");
    acc_chk(20'h00010, 0, 7, "R4 off repeat");
  endtask

  task automatic t_off();
    int lat; logic [31:0] dat; logic [TW-1:0] f0; bit fr;
    cfg(2'd0, 3'd3);
    access(20'h00120, 0, lat, dat, f0, fr);
    chk(lat == 3, "R4 off latency", 32'(lat), 3);
    chk(fr && f0 == 16'h0012, "R3 read addr", 32'(f0), 32'h12);
    #1;
    chk(fl_rd == 1'b0, "R4 no prefetch", 32'(fl_rd), 0);
    acc_chk(20'h00124, 0, 3, "R4 off same line");
    acc_chk(20'h00128, 1, 3, "R4 off data");
    cfg(2'd0, 3'd0);
    acc_chk(20'h0012C, 0, 1, "R2 latency 0 as 1");
  endtask

  task automatic t_stream();
    cfg(2'd1, 3'd4);
    acc_chk(20'h01000, 0, 4, "R6 first line");
    #1;
    chk(fl_rd && fl_addr == 16'h0101, "R5 next line read", 32'(fl_addr), 32'h101);
    for (int k = 1; k < 16; k++) acc_chk(20'h01000 + 20'(4*k), 0, 1, "R6 lat4 stream");
    cfg(2'd1, 3'd2);
    acc_chk(20'h02000, 0, 2, "R6 first line");
    for (int k = 1; k < 16; k++) acc_chk(20'h02000 + 20'(4*k), 0, 1, "R7 lat2 stream");
  endtask

  task automatic t_abort();
    int lat; logic [31:0] dat; logic [TW-1:0] f0; bit fr;
    cfg(2'd1, 3'd6);
    acc_chk(20'h03000, 0, 6, "R8 first");
    access(20'h05000, 0, lat, dat, f0, fr);
    chk(lat == 6, "R8 abort latency", 32'(lat), 6);
    chk(fr && f0 == 16'h0500, "R8 switch addr", 32'(f0), 32'h500);
    chk(dat == ew(20'h05000), "R1 data", dat, ew(20'h05000));
  endtask

  task automatic t_loop();
    int lat; logic [31:0] dat; logic [TW-1:0] f0; bit fr;
    cfg(2'd2, 3'd5);
    for (int it = 0; it < 3; it++) begin
      for (int k = 0; k < 12; k++) begin
        access(20'h06000 + 20'(4*k), 0, lat, dat, f0, fr);
        chk(dat == ew(20'h06000 + 20'(4*k)), "R1 loop data", dat,
            ew(20'h06000 + 20'(4*k)));
        if (k == 0 && it < 2) chk(lat == 5, "R9 loop entry miss", 32'(lat), 5);
        if (k == 0 && it == 2) chk(lat == 1, "R9 loop reentry hit", 32'(lat), 1);
      end
    end
  endtask

  task automatic t_data();
    cfg(2'd2, 3'd3);
    acc_chk(20'h07000, 0, 3, "R10 instr miss");
    acc_chk(20'h09004, 1, 3, "R10 data miss");
    acc_chk(20'h09008, 1, 1, "R10 data hit");
    acc_chk(20'h07004, 0, 1, "R10 instr kept");
    cfg(2'd1, 3'd3);
    acc_chk(20'h07000, 0, 3, "R10 partial instr");
    acc_chk(20'h09004, 1, 3, "R10 partial data");
    acc_chk(20'h09004, 1, 3, "R10 partial data not kept");
  endtask

  task automatic t_clear();
    cfg(2'd2, 3'd3);
    acc_chk(20'h0A000, 1, 3, "R11 fill");
    acc_chk(20'h0A000, 1, 1, "R7 hit");
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(req_ready == 1'b0, "R12 no ready", 32'(req_ready), 0);
      @(negedge clk);
    end
    cfg(2'd2, 3'd3);
    acc_chk(20'h0A000, 1, 3, "R11 cleared");
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_stream();
    t_abort();
    t_loop();
    t_data();
    t_clear();
    summary();
  end

endmodule